// File: doc/BRIEF.md
# Rotating-Clear Sticky Event Status Bank

This block turns single-cycle link events into sticky status bits that a controller samples with a read strobe. Each bit is held in three set/reset cells that share one event input, and the reported value is the OR of the three. A shared rotor chooses one cell to clear on each read. It picks cell A, then B, then C, and wraps back to A. Because only one cell is cleared per read, an event cannot slip through between a clear and the sample that follows it. The cost is that one event is usually reported on two reads instead of one.

Each bit has its own polarity, set by a mask parameter. An active-high bit idles at 0 and reads 1 after an event. A negative-logic bit idles at 1 and reads 0 after an event. On each read strobe the block registers the polarity-corrected values into a snapshot vector. The rotor's cell choice is also brought out, so the rotation can be seen at the ports. Shifting the snapshot out to a serial chain is done by the surrounding logic.

Top module: `sticky_evt_bank`

## Requirements
- R1: After reset every snapshot bit equals its polarity-mask bit (idle value), and the clear selector `clr_sel_o` is 3'b001 (cell A).
- R2: An event on a bit in a cycle without a read makes that bit read as asserted on the next two reads and as idle on the third.
- R3: Each read strobe advances `clr_sel_o` one-hot from 3'b001 to 3'b010 to 3'b100 and back to 3'b001. With no read it holds its value.
- R4: An event in the same cycle as a read wins over the clear. The bit reads asserted on that read and on the two reads after it, then idle on the third.
- R5: While the event input is asserted on every read, the bit keeps reading asserted. After the input goes quiet it reads asserted on two more reads and then idle.
- R6: A bit whose mask bit is 1 reads 1 when idle and 0 when asserted. Its return to 1 follows the same read counts as R2 and R4.
- R7: The snapshot changes only on a read strobe. Events between reads leave it unchanged until the next read.
- R8: Bits are independent: an event on one bit leaves every other bit's reported value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_BITS | Active-high event pulses, one per status bit, already synchronous to clk |
| rd_i | input | 1 | Read strobe: clears one cell per bit and loads the snapshot |
| snap_o | output | NUM_BITS | Polarity-corrected status captured at the last read |
| clr_sel_o | output | 3 | One-hot cell that the next read will clear (bit0 = A, bit1 = B, bit2 = C) |

## Verification
The bench builds the block with six bits and the polarity mask 6'b100110. This mixes active-high and negative-logic bits in one vector, so a single compare covers both polarities and also shows that neighbouring bits stay put. Six bits give room for events on separate bits to run in parallel while each is at a different point of its two-read decay. This lets the bench check events before a read, events coinciding with a read, sustained events and re-triggering. A reference counter per bit tracks the remaining asserted reads.

// File: rtl/sticky_evt_pkg.sv
package sticky_evt_pkg;

    localparam int CELLS = 3;

    typedef logic [CELLS-1:0] cell_vec_t;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2
    } cell_sel_e;

    function automatic cell_sel_e next_sel(input cell_sel_e cur);
        case (cur)
            SEL_A:   next_sel = SEL_B;
            SEL_B:   next_sel = SEL_C;
            default: next_sel = SEL_A;
        endcase
    endfunction

endpackage

// File: rtl/sticky_clr_rotor.sv
module sticky_clr_rotor
    import sticky_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_i,
    output cell_vec_t sel_onehot_o,
    output cell_vec_t clr_pulse_o
);

    typedef struct packed {
        cell_sel_e sel;
    } rotor_t;

    rotor_t st_d, st_q;
    cell_vec_t onehot;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.sel = next_sel(st_q.sel);
        end
        onehot = '0;
        for (int k = 0; k < CELLS; k++) begin
            if (st_q.sel == cell_sel_e'(k)) begin
                onehot[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= SEL_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_onehot_o = onehot;
    assign clr_pulse_o  = rd_i ? onehot : '0;

    // R3: exactly one cell is selected at all times
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel_onehot_o));

    // R3: a read moves the selection one position up, C wraps to A
    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> sel_onehot_o == {$past(sel_onehot_o[1:0]), $past(sel_onehot_o[2])});

    // R3: without a read the selection holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(sel_onehot_o));

endmodule

// File: rtl/sticky_cell_trio.sv
module sticky_cell_trio
    import sticky_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_i,
    input  cell_vec_t clr_i,
    output logic      level_nxt_o
);

    typedef struct packed {
        cell_vec_t cells;
    } trio_t;

    trio_t st_d, st_q;

    generate
        for (genvar k = 0; k < CELLS; k++) begin : g_cell
            // set has priority over the rotating clear
            assign st_d.cells[k] = evt_i | (st_q.cells[k] & ~clr_i[k]);
        end
    endgenerate

    assign level_nxt_o = |st_d.cells;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: an event fills all three cells even against a clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> st_q.cells == '1);

    // R2: a clear without an event empties the selected cell
    a_r2_clear_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i && !evt_i) |=> (st_q.cells & $past(clr_i)) == '0);

    // R2: at most one cell cleared per read
    a_r2_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_i));

endmodule

// File: rtl/sticky_evt_bank.sv
module sticky_evt_bank
    import sticky_evt_pkg::*;
#(
    parameter int                     NUM_BITS = 8,
    parameter logic [NUM_BITS-1:0]    NEG_MASK = 8'h0E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BITS-1:0] evt_i,
    input  logic                rd_i,
    output logic [NUM_BITS-1:0] snap_o,
    output logic [CELLS-1:0]    clr_sel_o
);

    typedef struct packed {
        logic [NUM_BITS-1:0] snap;
    } bank_t;

    bank_t st_d, st_q;
    cell_vec_t clr_pulse;
    cell_vec_t sel_onehot;
    logic [NUM_BITS-1:0] level_nxt;

    sticky_clr_rotor u_rotor (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (rd_i),
        .sel_onehot_o (sel_onehot),
        .clr_pulse_o  (clr_pulse)
    );

    generate
        for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
            sticky_cell_trio u_trio (
                .clk         (clk),
                .rst_n       (rst_n),
                .evt_i       (evt_i[i]),
                .clr_i       (clr_pulse),
                .level_nxt_o (level_nxt[i])
            );

            // R4, R6: a coincident event is reported asserted on that read
            a_r4_coincident: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_i && evt_i[i]) |=> snap_o[i] == ~NEG_MASK[i]);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.snap = level_nxt ^ NEG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.snap <= NEG_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o    = st_q.snap;
    assign clr_sel_o = sel_onehot;

    // R7: snapshot moves only on a read
    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(snap_o));

endmodule

// File: tb/sticky_evt_bank_tb.sv
`timescale 1ns/1ps
module sticky_evt_bank_tb;

    localparam int             NB = 6;
    localparam logic [NB-1:0]  NM = 6'b100110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 1'b0;
    logic [NB-1:0] evt = '0;
    logic [NB-1:0] snap;
    logic [2:0]    clr_sel;

    sticky_evt_bank #(.NUM_BITS(NB), .NEG_MASK(NM)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .rd_i      (rd),
        .snap_o    (snap),
        .clr_sel_o (clr_sel)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [NB-1:0] snap;
        logic [2:0]    sel;
        string         tag;
    } item_t;

    item_t         sb[$];
    int            checks = 0;
    int            fails = 0;
    int            rem[NB];
    logic [2:0]    exp_sel = 3'b001;
    logic [NB-1:0] last_snap = NM;
    bit            done = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // event pulse on a cycle without a read
    task automatic pulse(input logic [NB-1:0] m);
        @(negedge clk);
        evt = m;
        for (int b = 0; b < NB; b++) if (m[b]) rem[b] = 2;
        @(negedge clk);
        evt = '0;
    endtask

    // read strobe, optionally with coincident events
    task automatic do_read(input logic [NB-1:0] m, input string tag);
        item_t it;
        logic [NB-1:0] e;
        @(negedge clk);
        evt = m;
        rd  = 1'b1;
        for (int b = 0; b < NB; b++) begin
            logic asrt;
            if (m[b]) begin
                asrt = 1'b1;
                rem[b] = 2;
            end else begin
                asrt = (rem[b] > 0);
                if (rem[b] > 0) rem[b]--;
            end
            e[b] = asrt ^ NM[b];
        end
        exp_sel  = {exp_sel[1:0], exp_sel[2]};
        it.snap  = e;
        it.sel   = exp_sel;
        it.tag   = tag;
        last_snap = e;
        sb.push_back(it);
        @(negedge clk);
        rd  = 1'b0;
        evt = '0;
    endtask

    // monitor: pops and compares after each read edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd && rst_n) begin
                item_t it;
                @(negedge clk);
                it = sb.pop_front();
                chk({it.tag, " snapshot"}, 8'(snap), 8'(it.snap));
                chk({it.tag, " clr_sel R3"}, 8'(clr_sel), 8'(it.sel));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) rem[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset snapshot", 8'(snap), 8'(NM));
        chk("R1 reset clr_sel", 8'(clr_sel), 8'h01);

        // R3: plain reads rotate the selector through a full wrap
        for (int k = 0; k < 4; k++) do_read('0, "R3 idle read");
        repeat (3) @(negedge clk);
        chk("R3 selector holds without read", 8'(clr_sel), 8'(exp_sel));

        // R2: active-high bit0, two asserted reads then idle
        pulse(6'b000001);
        for (int k = 0; k < 3; k++) do_read('0, "R2 single event");

        // R6: negative-logic bit1
        pulse(6'b000010);
        for (int k = 0; k < 3; k++) do_read('0, "R6 negative bit");

        // R7: events between reads do not move the snapshot
        pulse(6'b111111);
        @(negedge clk);
        chk("R7 snapshot holds between reads", 8'(snap), 8'(last_snap));
        for (int k = 0; k < 3; k++) do_read('0, "R7 all bits decay");

        // R4: event coincident with read on bit3 (active high) and bit5 (negative)
        do_read(6'b101000, "R4 coincident event");
        for (int k = 0; k < 3; k++) do_read('0, "R4 after coincident");

        // R5: sustained event on bit5 across reads, then quiet
        @(negedge clk); evt = 6'b100000;
        for (int k = 0; k < 4; k++) do_read(6'b100000, "R5 sustained");
        for (int k = 0; k < 3; k++) do_read('0, "R5 after quiet");

        // R8: staggered events on bit2 and bit4 decay independently
        pulse(6'b000100);
        do_read('0, "R8 staggered first");
        pulse(6'b010000);
        for (int k = 0; k < 3; k++) do_read('0, "R8 staggered");

        // R2: retrigger mid-decay restarts the two-read window
        pulse(6'b000001);
        do_read('0, "R2 retrigger first");
        pulse(6'b000001);
        for (int k = 0; k < 3; k++) do_read('0, "R2 retrigger");

        repeat (4) @(negedge clk);
        chk("R7 scoreboard drained", 8'(sb.size()), 8'h00);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule